// File: doc/BRIEF.md
# Two-Wire Bus Clear Sequencer

This block frees a two-wire serial bus on which a target device has been left holding the data line low, for example after a transfer was cut off part way through a byte. When it is asked to, it takes over both bus lines through two open-drain pull-down enables. A set enable pulls its line low, and a clear enable lets the line float high.

The recovery waveform has a fixed shape. First come nine clock pulses, and the data line stays released during all of them. Each pulse is a phase with both lines released followed by a phase with the clock pulled low. Then both lines are pulled low together for one phase. Next the clock is released while data is still held low. Finally data is released as well, which puts a stop condition on the bus.

Every phase lasts a programmable number of clock cycles. The waveform therefore has the same timing at any system clock frequency. A one-cycle completion pulse marks the end of the sequence. Deciding that the bus is stuck, and the normal transfer logic, belong to other blocks.

Top module: `bus_clear_seq`

## Requirements
- R1: Out of reset, and whenever the sequencer is idle, both pull enables (`scl_pull_o`, `sda_pull_o`) are 0 and `done_o` is 0.
- R2: A high `start_i` sampled on a clock edge while idle starts a sequence. The first phase occupies the cycles that follow that edge.
- R3: Every phase lasts exactly `phase_len_i` cycles. A length of 0 is treated as 1, so a sequence occupies 21 phases of that length.
- R4: `phase_len_i` is captured when the sequence is accepted. Later changes to it do not alter the running sequence.
- R5: Phases 0 to 17 form nine pulses. An even phase has both enables at 0. An odd phase has `scl_pull_o`=1 and `sda_pull_o`=0.
- R6: Phase 18 has both enables at 1.
- R7: Phase 19 has `scl_pull_o`=0 and `sda_pull_o`=1. Phase 20 has both enables at 0, so data rises while the clock is released, which is a stop condition.
- R8: `done_o` is 1 for exactly the one cycle after phase 20, with both enables at 0 in that cycle. A start sampled at the end of that cycle is accepted.
- R9: A `start_i` pulse that arrives while a sequence is running is ignored. The sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the recovery sequence |
| phase_len_i | input | PHASE_W | Phase length in clock cycles (0 acts as 1) |
| scl_pull_o | output | 1 | Pull the clock line low when 1 |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The cycle numbering starts at the clock edge that samples `start_i`, which is cycle 0, so cycle n follows the n-th edge after it. Cycle n, with 1 ≤ n ≤ 21·L, belongs to phase (n−1)/L, where L is the effective phase length. The pull enables take that phase's levels in the same cycle, because they are decoded directly from registered state. `done_o` is due in cycle 21·L+1, and the next few cycles must be quiet. The bench sweeps several phase lengths, including 0 and 1, and compares both enables and the done pulse in every cycle of every sequence. It samples them on the falling clock edge against this arithmetic model, including runs with a stray start and a changed length mid-sequence, and a run restarted from the done cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Default number of clock pulses issued before the stop is formed.
  localparam int unsigned BCS_PULSES_DEF = 9;
  // Phases after the pulse train: both-low, data-low, release.
  localparam int unsigned BCS_TAIL_PHASES = 3;

  typedef struct packed {
    logic scl;
    logic sda;
  } bcs_pull_t;
endpackage

// File: rtl/bcs_phase_timer.sv
module bcs_phase_timer #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] len_i,
  input  logic               run_i,
  output logic               tick_o
);
  localparam logic [PHASE_W-1:0] ONE = {{(PHASE_W-1){1'b0}}, 1'b1};

  logic [PHASE_W-1:0] len_q, len_d, cnt_q, cnt_d, len_eff;
  logic               len_en, cnt_en;

  always_comb begin
    len_eff = (len_i == '0) ? ONE : len_i;
    len_en  = load_i;
    len_d   = len_eff;
    cnt_en  = load_i | run_i;
    if (load_i)
      cnt_d = len_eff - ONE;
    else if (cnt_q == '0)
      cnt_d = len_q - ONE;
    else
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= ONE;
      cnt_q <= '0;
    end else begin
      if (len_en) len_q <= len_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/bcs_step_ctrl.sv
module bcs_step_ctrl #(
  parameter int unsigned NPH    = 21,
  parameter int unsigned PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              accept_o,
  output logic              active_o,
  output logic [PIDX_W-1:0] phase_o,
  output logic              done_o
);
  localparam logic [PIDX_W-1:0] LAST = PIDX_W'(NPH - 1);

  logic              active_q, active_d, done_q, done_d, last;
  logic [PIDX_W-1:0] phase_q, phase_d;
  logic              phase_en;

  always_comb begin
    accept_o = start_i && !active_q;
    last     = (phase_q == LAST);
    active_d = active_q;
    phase_d  = phase_q;
    phase_en = 1'b0;
    done_d   = tick_i && last;
    if (accept_o) begin
      active_d = 1'b1;
      phase_d  = '0;
      phase_en = 1'b1;
    end else if (tick_i) begin
      if (last) begin
        active_d = 1'b0;
      end else begin
        phase_d  = phase_q + PIDX_W'(1);
        phase_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      if (phase_en) phase_q <= phase_d;
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign done_o   = done_q;
endmodule

// File: rtl/bcs_line_drive.sv
module bcs_line_drive
  import bcs_pkg::*;
#(
  parameter int unsigned PULSES = 9,
  parameter int unsigned PIDX_W = 5
) (
  input  logic              active_i,
  input  logic [PIDX_W-1:0] phase_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o
);
  localparam logic [PIDX_W-1:0] P_BOTH = PIDX_W'(2 * PULSES);
  localparam logic [PIDX_W-1:0] P_DATA = PIDX_W'(2 * PULSES + 1);

  bcs_pull_t pull;

  always_comb begin
    pull = '0;
    if (active_i) begin
      if (phase_i < P_BOTH) begin
        pull.scl = phase_i[0];
      end else if (phase_i == P_BOTH) begin
        pull.scl = 1'b1;
        pull.sda = 1'b1;
      end else if (phase_i == P_DATA) begin
        pull.sda = 1'b1;
      end
    end
  end

  assign scl_pull_o = pull.scl;
  assign sda_pull_o = pull.sda;
endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq #(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned PULSES  = bcs_pkg::BCS_PULSES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_len_i,
  output logic               scl_pull_o,
  output logic               sda_pull_o,
  output logic               done_o
);
  localparam int unsigned NPH    = 2 * PULSES + bcs_pkg::BCS_TAIL_PHASES;
  localparam int unsigned PIDX_W = $clog2(NPH);

  logic              accept, active_q, tick;
  logic [PIDX_W-1:0] phase_q;

  bcs_phase_timer #(.PHASE_W(PHASE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .len_i  (phase_len_i),
    .run_i  (active_q),
    .tick_o (tick)
  );

  bcs_step_ctrl #(.NPH(NPH), .PIDX_W(PIDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .tick_i   (tick),
    .accept_o (accept),
    .active_o (active_q),
    .phase_o  (phase_q),
    .done_o   (done_o)
  );

  bcs_line_drive #(.PULSES(PULSES), .PIDX_W(PIDX_W)) u_drive (
    .active_i   (active_q),
    .phase_i    (phase_q),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o)
  );
endmodule

// File: rtl/bus_clear_seq_chk.sv
module bus_clear_seq_chk #(
  parameter int unsigned PULSES = 9,
  parameter int unsigned PIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              scl_pull_o,
  input logic              sda_pull_o,
  input logic              done_o,
  input logic              active_i,
  input logic [PIDX_W-1:0] phase_i
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> (!scl_pull_o && !sda_pull_o));

  assert_data_free_in_pulses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (phase_i >= PIDX_W'(2 * PULSES)));

  assert_stop_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> (!scl_pull_o && $past(!scl_pull_o)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_i);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && start_i) |=> (!active_i || phase_i >= $past(phase_i)));
endmodule

bind bus_clear_seq bus_clear_seq_chk #(.PULSES(PULSES), .PIDX_W(PIDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .done_o     (done_o),
  .active_i   (active_q),
  .phase_i    (phase_q)
);

// File: tb/bus_clear_seq_bench.sv
module bus_clear_seq_bench;
  localparam int PHASE_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [PHASE_W-1:0] phase_len_i = '0;
  logic               scl_pull_o, sda_pull_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  bus_clear_seq #(.PHASE_W(PHASE_W), .PULSES(9)) u_bus_clear_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .phase_len_i (phase_len_i),
    .scl_pull_o  (scl_pull_o),
    .sda_pull_o  (sda_pull_o),
    .done_o      (done_o)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      finish_run();
    end
  end

  // Expected {scl,sda,done} in cycle n after the accepting edge.
  function automatic logic [2:0] model(int n, int len);
    int le, p;
    le = (len == 0) ? 1 : len;
    if (n >= 1 && n <= 21 * le) begin
      p = (n - 1) / le;
      if (p < 18)       return {p[0], 1'b0, 1'b0};
      else if (p == 18) return 3'b110;
      else if (p == 19) return 3'b010;
      else              return 3'b000;
    end else if (n == 21 * le + 1) begin
      return 3'b001;
    end
    return 3'b000;
  endfunction

  function automatic string tag_of(int n, int len);
    int le, p;
    le = (len == 0) ? 1 : len;
    if (n == 21 * le + 1) return "R8";
    if (n < 1 || n > 21 * le) return "R1";
    p = (n - 1) / le;
    if (p < 18) return "R5";
    if (p == 18) return "R6";
    return "R7";
  endfunction

  task automatic compare(string ctx, string tag, int n, logic [2:0] exp);
    logic [2:0] act;
    act = {scl_pull_o, sda_pull_o, done_o};
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s cycle %0d: actual scl/sda/done=%b expected %b",
               ctx, tag, n, act, exp);
    end
  endtask

  // Drive start in the current cycle so the next edge accepts it.
  task automatic arm(int len);
    @(negedge clk);
    phase_len_i = PHASE_W'(len);
    start_i = 1'b1;
    @(posedge clk);
  endtask

  // Walk one sequence from cycle 1. inject: stray start plus changed length (R4, R9).
  // chain: raise start in the done cycle and return at the accepting edge (R8).
  task automatic walk(string ctx, int len, bit inject, bit chain);
    int le, stop_n;
    le = (len == 0) ? 1 : len;
    stop_n = chain ? 21 * le + 1 : 21 * le + 3;
    for (int n = 1; n <= stop_n; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (inject && n == 3) begin
        start_i = 1'b1;
        phase_len_i = PHASE_W'(len + 7);
      end
      compare(ctx, tag_of(n, len), n, model(n, len));
      if (chain && n == stop_n) start_i = 1'b1;
    end
    if (chain) @(posedge clk);
    else begin
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("reset", "R1", 0, 3'b000);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare("idle", "R1", i, 3'b000);
    end

    // R2 R3: sweep of phase lengths, 0 acting as 1
    for (int len = 0; len <= 5; len++) begin
      arm(len);
      walk("R2/R3 sweep", len, 1'b0, 1'b0);
    end
    arm(12);
    walk("R2/R3 long", 12, 1'b0, 1'b0);

    // R4 R9: stray start and length change during a run
    for (int len = 1; len <= 4; len++) begin
      arm(len);
      walk("R4/R9 inject", len, 1'b1, 1'b0);
    end

    // R8: restart accepted from the done cycle
    arm(2);
    walk("R8 chain-a", 2, 1'b0, 1'b1);
    walk("R8 chain-b", 2, 1'b0, 1'b0);

    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      compare("tail idle", "R1", i, 3'b000);
    end
    finish_run();
  end
endmodule